// File: doc/BRIEF.md
# Dual-Regulator Power-Up Sequencer

This block is the digital controller that brings a two-output linear regulator up from shutdown and keeps it in a safe state. It watches two asynchronous channel enables, a digitized supply-good flag and a set of ready flags from the analog circuits. From these it drives the strobes that power the shared circuits one after another, and then the enables of the two output channels. The analog regulators, comparators and capacitors are outside the block. They appear only as flags.

With both enables low the block holds everything off. When an enable rises, the block waits for a good supply. It then latches trim, powers the bandgap, powers the reference and current generators, and fast-charges the reference bypass capacitor, in that order. Only after these steps may a channel turn on. One channel ramps at a time, and a channel asked for while the other is still ramping waits for the other's output-good flag. If the supply drops, everything switches off, and the sequence reruns by itself when the supply returns. A stage that never reports ready within `TMO_CYC` cycles sends the block to shutdown and sets a sticky fault.

Top module: `dr_seq_top`

## Requirements
- R1: After reset, and whenever both synchronized enables are low, every output is low: the trim strobe, bandgap enable, reference enable, bypass charge, both channel enables and the fault flag.
- R2: While an enable is high and `sup_ok_i` is low, the block waits with all outputs low. The trim strobe rises at the first clock edge at which `sup_ok_i` is seen high.
- R3: Shared bring-up is strictly ordered. The trim strobe comes first and is alone. The bandgap enable comes next. The reference enable follows the bandgap. The bypass charge comes last, with bandgap and reference still on. Each step advances at the first edge at which its ready flag is high. Trim and bypass charge are high only in their own steps. Bandgap and reference stay on while any channel is on.
- R4: A channel enabled while the other channel is ramping stays off until the ramping channel's output-good flag is seen. It turns on one edge after that. This holds in both directions.
- R5: When both channels are requested in the same cycle, channel 1 turns on first and channel 2 waits for output 1 good. The two channel enables never rise in the same cycle.
- R6: When `sup_ok_i` is low at a clock edge, every strobe and both channel enables are low after that edge and stay low while the supply is bad.
- R7: When `sup_ok_i` returns with an enable still high, the full sequence restarts from the trim step without any new enable edge.
- R8: Each wait, whether for a ready flag or for a channel's output-good flag, lasts at most `TMO_CYC` cycles from its start. A flag seen at the last of these edges is accepted. Otherwise, at that edge all outputs go low and the fault flag is set.
- R9: The fault flag and the shutdown it forces persist while either enable is high. They clear at the edge at which both synchronized enables are seen low.
- R10: Dropping one enable after bring-up turns off only that channel. The other channel and the shared circuits stay on.
- R11: Enables pass through a two-stage synchronizer and all outputs are registered. With the supply good, the trim strobe rises at the fourth edge after an enable rises from shutdown. A channel's enable falls at the third edge after its enable input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ena1_i | input | 1 | Channel 1 enable request (asynchronous) |
| ena2_i | input | 1 | Channel 2 enable request (asynchronous) |
| sup_ok_i | input | 1 | Supply above the start threshold (digitized lockout flag) |
| trim_done_i | input | 1 | Trim values latched |
| bg_rdy_i | input | 1 | Bandgap settled |
| ref_rdy_i | input | 1 | Reference and current generators settled |
| byp_rdy_i | input | 1 | Reference bypass capacitor charged |
| out1_good_i | input | 1 | Output 1 in regulation |
| out2_good_i | input | 1 | Output 2 in regulation |
| trim_o | output | 1 | Trim latch strobe |
| bg_on_o | output | 1 | Bandgap enable |
| ref_on_o | output | 1 | Reference and current generator enable |
| byp_o | output | 1 | Bypass capacitor fast-charge strobe |
| ch1_o | output | 1 | Channel 1 regulator enable |
| ch2_o | output | 1 | Channel 2 regulator enable |
| fault_o | output | 1 | Sticky start-up timeout fault |

## Verification
Each result has a fixed cycle at which it is due. A ready flag moves the strobes on the next edge. A bad supply clears all outputs on the next edge. A granted hand-over shows two edges after the output-good flag that frees it. An enable rising from shutdown reaches the trim strobe on the fourth edge, and an enable falling reaches its channel on the third. A timeout fires exactly `TMO_CYC` edges after its wait began. The bench changes inputs 1 ns after an edge and samples at the same point, counting whole edges. It checks the edge before each of these events as well as the edge it is due, so a result one cycle early or late is caught. A sweep over every wait stage and every arrival delay from one to `TMO_CYC`+1 cycles covers both sides of the timeout boundary.

// File: rtl/dr_seq_pkg.sv
`timescale 1ns/1ps
package dr_seq_pkg;

  // Shared bring-up states; the order of the wait states is the bring-up order.
  typedef enum logic [2:0] {
    SQ_OFF  = 3'd0,
    SQ_QUAL = 3'd1,
    SQ_TRIM = 3'd2,
    SQ_BIAS = 3'd3,
    SQ_REFG = 3'd4,
    SQ_BYPC = 3'd5,
    SQ_RUN  = 3'd6
  } sq_state_t;

  // Per-channel states.
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RAMP = 2'd1,
    CH_ON   = 2'd2
  } ch_state_t;

endpackage

// File: rtl/dr_sync.sv
`timescale 1ns/1ps
module dr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] r_q;
    if (s == 0) begin : g_head
      assign src = d_i;
    end else begin : g_tail
      assign src = g_stg[s-1].r_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= src;
    end
  end

  assign q_o = g_stg[STAGES-1].r_q;

endmodule

// File: rtl/dr_timer.sv
`timescale 1ns/1ps
module dr_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic hit_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i | run_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit_o = run_i && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/dr_chan.sv
`timescale 1ns/1ps
module dr_chan import dr_seq_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic req_i,
  input  logic grant_i,
  input  logic good_i,
  output logic ramp_o,
  output logic en_o
);

  ch_state_t st_q, st_d;
  logic      en_q;

  always_comb begin
    st_d = st_q;
    if (!run_i || !req_i) begin
      st_d = CH_IDLE;
    end else begin
      case (st_q)
        CH_IDLE: if (grant_i) st_d = CH_RAMP;
        CH_RAMP: if (good_i)  st_d = CH_ON;
        CH_ON:   st_d = CH_ON;
        default: st_d = CH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CH_IDLE;
      en_q <= 1'b0;
    end else begin
      st_q <= st_d;
      en_q <= (st_d != CH_IDLE);
    end
  end

  assign ramp_o = (st_q == CH_RAMP);
  assign en_o   = en_q;

endmodule

// File: rtl/dr_seq_top.sv
`timescale 1ns/1ps
module dr_seq_top import dr_seq_pkg::*; #(
  parameter int TMO_CYC     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ena1_i,
  input  logic ena2_i,
  input  logic sup_ok_i,
  input  logic trim_done_i,
  input  logic bg_rdy_i,
  input  logic ref_rdy_i,
  input  logic byp_rdy_i,
  input  logic out1_good_i,
  input  logic out2_good_i,
  output logic trim_o,
  output logic bg_on_o,
  output logic ref_on_o,
  output logic byp_o,
  output logic ch1_o,
  output logic ch2_o,
  output logic fault_o
);

  localparam int NCH = 2;

  // ---------------- enable synchronizer
  logic [NCH-1:0] en_s;
  logic           any_en;

  dr_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({ena2_i, ena1_i}),
    .q_o  (en_s)
  );

  assign any_en = |en_s;

  // ---------------- shared state
  sq_state_t st_q, st_d;
  logic      fault_q, fault_d;
  logic      set_flt;
  logic      tmo_hit;
  logic      wait_now;
  logic      tmr_clr;
  logic      run_ok;

  logic [NCH-1:0] ch_good;
  logic [NCH-1:0] ch_ramp;
  logic [NCH-1:0] ch_on;
  logic [NCH-1:0] grant;

  assign ch_good = {out2_good_i, out1_good_i};

  always_comb begin
    wait_now = 1'b0;
    case (st_q)
      SQ_TRIM, SQ_BIAS, SQ_REFG, SQ_BYPC: wait_now = 1'b1;
      SQ_RUN:                             wait_now = |ch_ramp;
      default:                            wait_now = 1'b0;
    endcase
  end

  // next-state process of the shared chain
  always_comb begin
    st_d    = st_q;
    set_flt = 1'b0;
    if (!any_en || fault_q) begin
      st_d = SQ_OFF;
    end else if (st_q != SQ_OFF && st_q != SQ_QUAL && !sup_ok_i) begin
      st_d = SQ_QUAL;
    end else begin
      case (st_q)
        SQ_OFF:  st_d = SQ_QUAL;
        SQ_QUAL: if (sup_ok_i) st_d = SQ_TRIM;
        SQ_TRIM: begin
          if (trim_done_i)  st_d = SQ_BIAS;
          else if (tmo_hit) set_flt = 1'b1;
        end
        SQ_BIAS: begin
          if (bg_rdy_i)     st_d = SQ_REFG;
          else if (tmo_hit) set_flt = 1'b1;
        end
        SQ_REFG: begin
          if (ref_rdy_i)    st_d = SQ_BYPC;
          else if (tmo_hit) set_flt = 1'b1;
        end
        SQ_BYPC: begin
          if (byp_rdy_i)    st_d = SQ_RUN;
          else if (tmo_hit) set_flt = 1'b1;
        end
        SQ_RUN: begin
          if (tmo_hit && !(|(ch_ramp & ch_good))) set_flt = 1'b1;
        end
        default: st_d = SQ_OFF;
      endcase
    end
    if (set_flt) st_d = SQ_OFF;
  end

  assign fault_d = any_en & (fault_q | set_flt);
  assign run_ok  = (st_d == SQ_RUN);

  // ---------------- channel arbitration: one ramp at a time, lower index wins
  always_comb begin
    logic claim;
    claim = |ch_ramp;
    for (int c = 0; c < NCH; c++) begin
      grant[c] = run_ok && en_s[c] && !ch_on[c] && !claim;
      claim    = claim | grant[c];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dr_chan u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_ok),
      .req_i  (en_s[c]),
      .grant_i(grant[c]),
      .good_i (ch_good[c]),
      .ramp_o (ch_ramp[c]),
      .en_o   (ch_on[c])
    );
  end

  // ---------------- stage timeout
  assign tmr_clr = (st_d != st_q) | (|grant);

  dr_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(tmr_clr),
    .run_i(wait_now),
    .hit_o(tmo_hit)
  );

  // ---------------- registers
  logic [3:0] bias_d, bias_q;

  always_comb begin
    bias_d[0] = (st_d == SQ_TRIM);
    bias_d[1] = (st_d inside {SQ_BIAS, SQ_REFG, SQ_BYPC, SQ_RUN});
    bias_d[2] = (st_d inside {SQ_REFG, SQ_BYPC, SQ_RUN});
    bias_d[3] = (st_d == SQ_BYPC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_OFF;
      fault_q <= 1'b0;
      bias_q  <= '0;
    end else begin
      st_q    <= st_d;
      fault_q <= fault_d;
      bias_q  <= bias_d;
    end
  end

  assign trim_o   = bias_q[0];
  assign bg_on_o  = bias_q[1];
  assign ref_on_o = bias_q[2];
  assign byp_o    = bias_q[3];
  assign ch1_o    = ch_on[0];
  assign ch2_o    = ch_on[1];
  assign fault_o  = fault_q;

endmodule

// File: rtl/dr_seq_chk.sv
`timescale 1ns/1ps
module dr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sup_ok_i,
  input logic trim_o,
  input logic bg_on_o,
  input logic ref_on_o,
  input logic byp_o,
  input logic ch1_o,
  input logic ch2_o,
  input logic fault_o
);

  // R3: a channel is only on with the shared circuits up and the chain finished
  p_chan_bias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_o || ch2_o) |-> (bg_on_o && ref_on_o && !trim_o && !byp_o));

  // R3: trim, bypass charge and channel operation never overlap
  p_phase_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trim_o, byp_o, ch1_o || ch2_o}));

  // R3: the bandgap is only started straight from the trim step
  p_bg_after_trim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bg_on_o) |-> $past(trim_o));

  // R5: the two channels never start in the same cycle
  p_no_joint_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(ch1_o) && $rose(ch2_o)));

  // R6: a bad supply clears everything at the next edge
  p_brownout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok_i |=> !(trim_o || bg_on_o || ref_on_o || byp_o || ch1_o || ch2_o));

  // R8: a fault forces full shutdown
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !(trim_o || bg_on_o || ref_on_o || byp_o || ch1_o || ch2_o));

endmodule

bind dr_seq_top dr_seq_chk u_chk (.*);

// File: tb/sim_dr_seq_top.sv
`timescale 1ns/1ps
module sim_dr_seq_top;

  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ena1_i, ena2_i, sup_ok_i;
  logic trim_done_i, bg_rdy_i, ref_rdy_i, byp_rdy_i, out1_good_i, out2_good_i;
  logic trim_o, bg_on_o, ref_on_o, byp_o, ch1_o, ch2_o, fault_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  dr_seq_top #(.TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ena1_i(ena1_i), .ena2_i(ena2_i), .sup_ok_i(sup_ok_i),
    .trim_done_i(trim_done_i), .bg_rdy_i(bg_rdy_i), .ref_rdy_i(ref_rdy_i),
    .byp_rdy_i(byp_rdy_i), .out1_good_i(out1_good_i), .out2_good_i(out2_good_i),
    .trim_o(trim_o), .bg_on_o(bg_on_o), .ref_on_o(ref_on_o), .byp_o(byp_o),
    .ch1_o(ch1_o), .ch2_o(ch2_o), .fault_o(fault_o)
  );

  // Output vector {fault, ch2, ch1, byp, ref, bg, trim}
  localparam logic [6:0] V_OFF  = 7'b0000000;
  localparam logic [6:0] V_CH2  = 7'b0100110;
  localparam logic [6:0] V_BOTH = 7'b0110110;

  function automatic logic [6:0] stg(int k);
    case (k)
      1:       return 7'b0000001; // trim step
      2:       return 7'b0000010; // bandgap step
      3:       return 7'b0000110; // reference step
      4:       return 7'b0001110; // bypass charge step
      5:       return 7'b0010110; // running, channel 1 on
      6:       return 7'b1000000; // fault
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(logic [6:0] exp, string tag);
    logic [6:0] got;
    got = {fault_o, ch2_o, ch1_o, byp_o, ref_on_o, bg_on_o, trim_o};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic set_flag(int k);
    case (k)
      0: trim_done_i = 1'b1;
      1: bg_rdy_i    = 1'b1;
      2: ref_rdy_i   = 1'b1;
      3: byp_rdy_i   = 1'b1;
      default: out1_good_i = 1'b1;
    endcase
  endtask

  task automatic idle_all();
    ena1_i = 1'b0; ena2_i = 1'b0; sup_ok_i = 1'b1;
    trim_done_i = 1'b0; bg_rdy_i = 1'b0; ref_rdy_i = 1'b0; byp_rdy_i = 1'b0;
    out1_good_i = 1'b0; out2_good_i = 1'b0;
    step(5);
  endtask

  task automatic up(logic e1, logic e2);
    idle_all();
    ena1_i = e1; ena2_i = e2;
    step(3);
    chk(V_OFF, "R11 no trim three edges after enable");
    step(1);
    chk(stg(1), "R11 trim four edges after enable");
    trim_done_i = 1'b1; bg_rdy_i = 1'b1; ref_rdy_i = 1'b1; byp_rdy_i = 1'b1;
    step(4);
    chk(e1 ? stg(5) : V_CH2, "R3 chain complete with all flags ready");
  endtask

  // One bring-up in which wait stage 'sel' sees its flag 'd' cycles after entry.
  task automatic sweep_one(int sel, int d);
    idle_all();
    ena1_i = 1'b1;
    step(4);
    chk(stg(1), "R11 trim entry in sweep");
    for (int k = 0; k < 5; k++) begin
      int dk;
      dk = (k == sel) ? d : 1;
      if (dk <= TMO) begin
        if (dk > 1) step(dk - 1);
        set_flag(k);
        step(1);
        if (k < 4) begin
          chk(stg(k + 2), "R3 advance on ready flag");
        end else begin
          step(TMO + 2);
          chk(stg(5), "R8 ramp accepted within window");
        end
      end else begin
        step(TMO - 1);
        chk(stg(k + 1), "R8 still waiting on last cycle of window");
        step(1);
        chk(stg(6), "R8 timeout forces fault shutdown");
        break;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ena1_i = 1'b0; ena2_i = 1'b0; sup_ok_i = 1'b1;
    trim_done_i = 1'b0; bg_rdy_i = 1'b0; ref_rdy_i = 1'b0; byp_rdy_i = 1'b0;
    out1_good_i = 1'b0; out2_good_i = 1'b0;
    step(3);
    chk(V_OFF, "R1 outputs low in reset");
    rst_n = 1'b1;
    step(4);
    chk(V_OFF, "R1 outputs low with enables low");

    // R2: supply qualification
    idle_all();
    sup_ok_i = 1'b0; ena1_i = 1'b1;
    step(8);
    chk(V_OFF, "R2 waits for supply good");
    sup_ok_i = 1'b1;
    step(1);
    chk(stg(1), "R2 trim one edge after supply good");

    // R5: simultaneous requests, channel 1 first
    up(1'b1, 1'b1);
    step(3);
    chk(stg(5), "R5 channel 2 held while channel 1 ramps");
    out1_good_i = 1'b1;
    step(1);
    chk(stg(5), "R5 channel 2 not yet on at output 1 good edge");
    step(1);
    chk(V_BOTH, "R5 channel 2 on after output 1 good");
    out2_good_i = 1'b1;
    step(2);

    // R10: one channel off, shared circuits stay
    ena2_i = 1'b0;
    step(2);
    chk(V_BOTH, "R11 channel 2 still on two edges after enable fall");
    step(1);
    chk(stg(5), "R10 only channel 2 off");
    ena1_i = 1'b0;
    step(3);
    chk(V_OFF, "R1 shutdown when both enables low");

    // R4: channel 2 asked while channel 1 ramps
    up(1'b1, 1'b0);
    ena2_i = 1'b1;
    step(3);
    chk(stg(5), "R4 channel 2 held behind ramping channel 1");
    out1_good_i = 1'b1;
    step(1);
    chk(stg(5), "R4 channel 2 still off at good edge");
    step(1);
    chk(V_BOTH, "R4 channel 2 on after output 1 good");
    out2_good_i = 1'b1;

    // R4 mirror: channel 1 asked while channel 2 ramps
    up(1'b0, 1'b1);
    ena1_i = 1'b1;
    step(3);
    chk(V_CH2, "R4 channel 1 held behind ramping channel 2");
    out2_good_i = 1'b1;
    step(1);
    chk(V_CH2, "R4 channel 1 still off at good edge");
    step(1);
    chk(V_BOTH, "R4 channel 1 on after output 2 good");
    out1_good_i = 1'b1;
    step(1);
    chk(V_BOTH, "R4 both channels running");

    // R6 / R7: brownout and automatic restart
    sup_ok_i = 1'b0;
    step(1);
    chk(V_OFF, "R6 all off one edge after supply loss");
    step(4);
    chk(V_OFF, "R6 all off while supply bad");
    sup_ok_i = 1'b1;
    step(1);
    chk(stg(1), "R7 restart at trim step");
    step(1);
    chk(stg(2), "R7 restart bandgap step");
    step(1);
    chk(stg(3), "R7 restart reference step");
    step(1);
    chk(stg(4), "R7 restart bypass step");
    step(1);
    chk(stg(5), "R7 restart channel 1 first");
    step(2);
    chk(V_BOTH, "R7 both channels back");

    // R8 / R9: timeout fault, sticky, cleared by both enables low
    idle_all();
    ena1_i = 1'b1;
    step(4);
    chk(stg(1), "R8 trim entry");
    step(TMO - 1);
    chk(stg(1), "R8 trim held until window end");
    step(1);
    chk(stg(6), "R8 fault at window end");
    step(5);
    chk(stg(6), "R9 fault sticky while enabled");
    ena1_i = 1'b0;
    step(2);
    chk(stg(6), "R9 fault held two edges after enables low");
    step(1);
    chk(V_OFF, "R9 fault cleared");

    // R8 / R3: sweep every wait stage over every arrival delay
    for (int s = 0; s < 5; s++) begin
      for (int d = 1; d <= TMO + 1; d++) begin
        sweep_one(s, d);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule